// File: doc/BRIEF.md
# Event Timestamp Capture Latch

This block records the moment an event happens. When an asynchronous event pin changes level in the chosen direction, or when an on-chip event line pulses, the block copies the full calendar value that it receives from a separate counter into a one-entry timestamp register. It then raises a status flag and an interrupt. The calendar counter is outside this block; it presents its current value on a flat input bus.

Only one capture can be held at a time. A further event that arrives while the flag is still set does not touch the stored value. Instead it sets a sticky overrun bit, so the first capture is never replaced by a later one. The host services a capture in a fixed order: it reads status, then reads the stamp, then writes a clear strobe. A clear strobe that does not follow that order is ignored. Because of this rule, a capture cannot be dropped or confused with a different event between the host's reads.

Top module: `evt_stamp_latch`

## Requirements
- R1: After reset, tsFlag, tsOverrun and irq are 0, and stamp and stampSrc are all zeros.
- R2: When fallSel is 0, a low-to-high change on evtPin causes a capture. When fallSel is 1, a high-to-low change on evtPin causes a capture. A change in the other direction leaves tsFlag at 0.
- R3: After evtPin changes (the change is set up before a rising clock edge), tsFlag is still 0 after the second rising edge and is 1 after the third.
- R4: A one-cycle pulse on evtInt causes a capture at the next rising edge, with stampSrc = 1. A capture from the pin sets stampSrc = 0. If a pin edge and an evtInt pulse are accepted in the same cycle, a single capture is made with stampSrc = 0 and tsOverrun stays 0.
- R5: stamp takes the value calNow had during the cycle just before the capture edge. A calendar update registered on that same edge does not appear in stamp. The calNow bit layout is, MSB to LSB: year 7, month 4, day 5, hour 5, minute 6, second 6. The block stores all bits unchanged.
- R6: irq is 1 exactly while tsFlag is 1.
- R7: An event that arrives while tsFlag is 1 leaves stamp and stampSrc unchanged and sets tsOverrun. tsOverrun stays at 1 until a clear is accepted.
- R8: A clrFlag pulse is accepted only if, since the capture, rdStatus was pulsed and rdStamp was pulsed after it. Any other order, or a missing step, leaves tsFlag set. A read pulse that arrives while tsFlag is 0 does not count toward the order.
- R9: An accepted clear sets tsFlag and tsOverrun to 0 on the next edge. Read pulses alone never change tsFlag.
- R10: If an event arrives in the same cycle as an accepted clear, the new event is captured. tsFlag stays 1, stamp takes the new value, and tsOverrun becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtPin | input | 1 | Asynchronous external event pin |
| evtInt | input | 1 | Synchronous on-chip event pulse |
| fallSel | input | 1 | 0: capture on a rising pin edge; 1: capture on a falling pin edge |
| calNow | input | CAL_W | Current calendar value from the counter |
| rdStatus | input | 1 | Host status-read strobe |
| rdStamp | input | 1 | Host stamp-read strobe |
| clrFlag | input | 1 | Host write-one clear strobe |
| tsFlag | output | 1 | Capture pending |
| tsOverrun | output | 1 | Sticky overrun |
| irq | output | 1 | Interrupt, level |
| stamp | output | CAL_W | Captured calendar value |
| stampSrc | output | 1 | 0: captured from the pin; 1: captured from the on-chip line |

## Verification
Each result has a fixed delay:
- A pin change shows up on tsFlag, stamp and stampSrc after the third rising edge. The bench checks after the second edge that the flag has not yet risen, and samples the captured values after the third edge.
- An evtInt pulse, and any host strobe, takes effect at the next edge. The bench drives every stimulus on the falling edge and checks at the following falling edge.
- The expected stamp is the calendar value the bench read at the falling edge just before the capture edge. The bench's calendar advances on every rising edge, so a stamp that is one cycle late is caught.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
  // Host service progress since the current capture
  typedef enum logic [1:0] {
    SVC_ARMED  = 2'd0,
    SVC_STATUS = 2'd1,
    SVC_STAMP  = 2'd2
  } svcState_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;
    logic fromInternal;
  } capStrobe_t;
endpackage

// File: rtl/evt_stamp_edge.sv
module evt_stamp_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic evtPin,
  input  logic fallSel,
  output logic edgeHit
);
  logic [STAGES-1:0] syncQ;
  logic              prevQ;
  logic              lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= evtPin;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[STAGES-2:0], evtPin};
      end
    end
  endgenerate

  assign lvl = syncQ[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= lvl;
  end

  assign edgeHit = fallSel ? (prevQ & ~lvl) : (~prevQ & lvl);
endmodule

// File: rtl/evt_stamp_ctrl.sv
module evt_stamp_ctrl
  import evt_stamp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinEdge,
  input  logic       evtInt,
  input  logic       rdStatus,
  input  logic       rdStamp,
  input  logic       clrFlag,
  output capStrobe_t strb,
  output logic       tsFlag,
  output logic       tsOverrun
);
  svcState_e svcQ, svcD;
  logic flagQ, flagD, ovrQ, ovrD;
  logic anyEvt, clrOk, take;

  assign anyEvt = pinEdge | evtInt;
  assign clrOk  = clrFlag & flagQ & (svcQ == SVC_STAMP);
  assign take   = anyEvt & (~flagQ | clrOk);

  assign strb.capture      = take;
  assign strb.fromInternal = evtInt & ~pinEdge;

  always_comb begin
    flagD = flagQ;
    ovrD  = ovrQ;
    svcD  = svcQ;
    if (flagQ) begin
      case (svcQ)
        SVC_ARMED:  if (rdStatus) svcD = SVC_STATUS;
        SVC_STATUS: if (rdStamp)  svcD = SVC_STAMP;
        default:    svcD = svcQ;
      endcase
    end
    if (clrOk) begin
      flagD = 1'b0;
      ovrD  = 1'b0;
      svcD  = SVC_ARMED;
    end
    if (anyEvt) begin
      if (take) begin
        flagD = 1'b1;
        ovrD  = 1'b0;
        svcD  = SVC_ARMED;
      end else begin
        ovrD = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      ovrQ  <= 1'b0;
      svcQ  <= SVC_ARMED;
    end else begin
      flagQ <= flagD;
      ovrQ  <= ovrD;
      svcQ  <= svcD;
    end
  end

  assign tsFlag    = flagQ;
  assign tsOverrun = ovrQ;
endmodule

// File: rtl/evt_stamp_dp.sv
module evt_stamp_dp
  import evt_stamp_pkg::*;
#(
  parameter int CAL_W = 33
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       strb,
  input  logic [CAL_W-1:0] calNow,
  output logic [CAL_W-1:0] stamp,
  output logic             stampSrc
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stamp    <= '0;
      stampSrc <= 1'b0;
    end else if (strb.capture) begin
      stamp    <= calNow;
      stampSrc <= strb.fromInternal;
    end
  end
endmodule

// File: rtl/evt_stamp_latch.sv
module evt_stamp_latch
  import evt_stamp_pkg::*;
#(
  parameter int CAL_W       = 33,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtPin,
  input  logic             evtInt,
  input  logic             fallSel,
  input  logic [CAL_W-1:0] calNow,
  input  logic             rdStatus,
  input  logic             rdStamp,
  input  logic             clrFlag,
  output logic             tsFlag,
  output logic             tsOverrun,
  output logic             irq,
  output logic [CAL_W-1:0] stamp,
  output logic             stampSrc
);
  logic       pinEdge;
  capStrobe_t strb;

  evt_stamp_edge #(.STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rstN(rstN), .evtPin(evtPin), .fallSel(fallSel), .edgeHit(pinEdge)
  );

  evt_stamp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pinEdge(pinEdge), .evtInt(evtInt),
    .rdStatus(rdStatus), .rdStamp(rdStamp), .clrFlag(clrFlag),
    .strb(strb), .tsFlag(tsFlag), .tsOverrun(tsOverrun)
  );

  evt_stamp_dp #(.CAL_W(CAL_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .calNow(calNow),
    .stamp(stamp), .stampSrc(stampSrc)
  );

  assign irq = tsFlag;
endmodule

// File: rtl/evt_stamp_latch_chk.sv
module evt_stamp_latch_chk #(
  parameter int CAL_W = 33
) (
  input logic             clk,
  input logic             rstN,
  input logic             pinEdge,
  input logic             evtInt,
  input logic             clrFlag,
  input logic             tsFlag,
  input logic             tsOverrun,
  input logic [CAL_W-1:0] stamp,
  input logic             stampSrc
);
  p_ovr_implies_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    tsOverrun |-> tsFlag);

  p_stamp_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tsFlag) && !$past(clrFlag)) |-> ($stable(stamp) && $stable(stampSrc)));

  p_ovr_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tsOverrun) |-> ($past(tsFlag) && ($past(pinEdge) || $past(evtInt))));

  p_fall_needs_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tsFlag) |-> $past(clrFlag));

  p_read_no_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tsFlag && !clrFlag) |=> tsFlag);

  p_capture_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tsFlag) |-> ($past(pinEdge) || $past(evtInt)));
endmodule

bind evt_stamp_latch evt_stamp_latch_chk #(.CAL_W(CAL_W)) chk_i (
  .clk(clk), .rstN(rstN), .pinEdge(pinEdge), .evtInt(evtInt), .clrFlag(clrFlag),
  .tsFlag(tsFlag), .tsOverrun(tsOverrun), .stamp(stamp), .stampSrc(stampSrc)
);

// File: tb/evt_stamp_latch_tb_top.sv
`timescale 1ns/1ps
module evt_stamp_latch_tb_top;
  localparam int CAL_W = 33;
  localparam logic [CAL_W-1:0] CAL_START = 33'h0_1234_5670;

  logic clk = 1'b0;
  logic rstN, evtPin, evtInt, fallSel, rdStatus, rdStamp, clrFlag;
  logic [CAL_W-1:0] calNow;
  logic tsFlag, tsOverrun, irq, stampSrc;
  logic [CAL_W-1:0] stamp;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // Upstream calendar model: advances on every rising edge
  always @(posedge clk) begin
    if (!rstN) calNow <= CAL_START;
    else       calNow <= calNow + 1'b1;
  end

  evt_stamp_latch #(.CAL_W(CAL_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .evtPin(evtPin), .evtInt(evtInt), .fallSel(fallSel),
    .calNow(calNow), .rdStatus(rdStatus), .rdStamp(rdStamp), .clrFlag(clrFlag),
    .tsFlag(tsFlag), .tsOverrun(tsOverrun), .irq(irq), .stamp(stamp), .stampSrc(stampSrc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int op);
    if (op == 0) rdStatus = 1'b1;
    else if (op == 1) rdStamp = 1'b1;
    else clrFlag = 1'b1;
    tick();
    rdStatus = 1'b0; rdStamp = 1'b0; clrFlag = 1'b0;
  endtask

  task automatic service();
    pulse(0); pulse(1); pulse(2);
  endtask

  // Pin change: flag is due after the third rising edge
  task automatic pinEvt(input logic preFlag, output logic [CAL_W-1:0] expV);
    evtPin = ~evtPin;
    tick();
    tick();
    expV = calNow;
    chk("R3 flag not before third edge", {63'd0, tsFlag}, {63'd0, preFlag});
    tick();
  endtask

  task automatic intEvt(output logic [CAL_W-1:0] expV);
    evtInt = 1'b1;
    expV = calNow;
    tick();
    evtInt = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [CAL_W-1:0] e1, e2;
    rstN = 1'b0; evtPin = 1'b0; evtInt = 1'b0; fallSel = 1'b0;
    rdStatus = 1'b0; rdStamp = 1'b0; clrFlag = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();

    // R1 reset state
    chk("R1 flag", {63'd0, tsFlag}, 64'd0);
    chk("R1 overrun", {63'd0, tsOverrun}, 64'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);
    chk("R1 stamp", {31'd0, stamp}, 64'd0);
    chk("R1 src", {63'd0, stampSrc}, 64'd0);

    // R2/R3/R5/R6 sweep: polarity x edge direction, twice each
    for (int pol = 0; pol < 2; pol++) begin
      fallSel = pol[0];
      tick();
      for (int n = 0; n < 4; n++) begin
        logic wantCap;
        wantCap = (pol == 0) ? ~evtPin : evtPin;  // evtPin before flip
        pinEvt(1'b0, e1);
        chk("R2 polarity select", {63'd0, tsFlag}, {63'd0, wantCap});
        if (wantCap) begin
          chk("R5 pin stamp value", {31'd0, stamp}, {31'd0, e1});
          chk("R4 pin source", {63'd0, stampSrc}, 64'd0);
          chk("R6 irq follows flag", {63'd0, irq}, 64'd1);
          service();
          chk("R9 clear after ordered service", {63'd0, tsFlag}, 64'd0);
          chk("R6 irq drops", {63'd0, irq}, 64'd0);
        end
      end
    end

    // R4/R5 internal event
    fallSel = 1'b0;
    if (evtPin) begin
      evtPin = 1'b0;  // falling edge, ignored in rising mode
      repeat (4) tick();
    end
    intEvt(e1);
    chk("R4 internal flag", {63'd0, tsFlag}, 64'd1);
    chk("R4 internal source", {63'd0, stampSrc}, 64'd1);
    chk("R5 internal stamp value", {31'd0, stamp}, {31'd0, e1});
    service();

    // R4 pin and internal in the same cycle
    evtPin = 1'b1;
    tick();
    tick();
    evtInt = 1'b1;
    e1 = calNow;
    tick();
    evtInt = 1'b0;
    chk("R4 simultaneous single capture", {63'd0, tsFlag}, 64'd1);
    chk("R4 simultaneous source pin", {63'd0, stampSrc}, 64'd0);
    chk("R4 simultaneous no overrun", {63'd0, tsOverrun}, 64'd0);
    chk("R4 simultaneous stamp", {31'd0, stamp}, {31'd0, e1});
    service();

    // R7 overrun from internal then pin
    intEvt(e1);
    repeat (2) tick();
    intEvt(e2);
    chk("R7 overrun set", {63'd0, tsOverrun}, 64'd1);
    chk("R7 first stamp kept", {31'd0, stamp}, {31'd0, e1});
    chk("R7 first source kept", {63'd0, stampSrc}, 64'd1);
    evtPin = 1'b0;  // falling edge, ignored
    repeat (4) tick();
    pinEvt(1'b1, e2);  // rising edge while flag set
    chk("R7 pin overrun keeps stamp", {31'd0, stamp}, {31'd0, e1});
    chk("R7 pin overrun keeps source", {63'd0, stampSrc}, 64'd1);
    repeat (5) tick();
    chk("R7 overrun sticky", {63'd0, tsOverrun}, 64'd1);
    pulse(0); pulse(1);
    chk("R9 reads leave flag", {63'd0, tsFlag}, 64'd1);
    pulse(2);
    chk("R9 clear drops flag", {63'd0, tsFlag}, 64'd0);
    chk("R9 clear drops overrun", {63'd0, tsOverrun}, 64'd0);

    // R8 exhaustive three-strobe orderings
    for (int code = 0; code < 27; code++) begin
      int ops[3];
      bit sawS, sawST, cleared;
      ops[0] = code % 3; ops[1] = (code / 3) % 3; ops[2] = code / 9;
      sawS = 0; sawST = 0; cleared = 0;
      intEvt(e1);
      for (int k = 0; k < 3; k++) begin
        pulse(ops[k]);
        if (!cleared) begin
          if (ops[k] == 0) sawS = 1;
          else if (ops[k] == 1) begin if (sawS) sawST = 1; end
          else if (sawST) cleared = 1;
        end
      end
      chk($sformatf("R8 order %0d%0d%0d", ops[0], ops[1], ops[2]),
          {63'd0, tsFlag}, {63'd0, !cleared});
      if (tsFlag) service();
    end

    // R8 reads while idle do not count
    pulse(0); pulse(1);
    intEvt(e1);
    pulse(2);
    chk("R8 idle reads ignored", {63'd0, tsFlag}, 64'd1);
    service();

    // R10 event together with accepted clear
    intEvt(e1);
    intEvt(e2);
    chk("R7 overrun before r10", {63'd0, tsOverrun}, 64'd1);
    pulse(0); pulse(1);
    clrFlag = 1'b1; evtInt = 1'b1;
    e2 = calNow;
    tick();
    clrFlag = 1'b0; evtInt = 1'b0;
    chk("R10 flag stays", {63'd0, tsFlag}, 64'd1);
    chk("R10 new stamp", {31'd0, stamp}, {31'd0, e2});
    chk("R10 overrun cleared", {63'd0, tsOverrun}, 64'd0);
    service();
    chk("R9 final clear", {63'd0, tsFlag}, 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule